// File: doc/BRIEF.md
# I2C Master Byte Engine

This block drives a two-wire serial bus as its only master. A host hands it one command at a time: emit a start condition, emit a stop condition, send a byte, or receive a byte. Each command carries a data byte and two flags, one asking for a stop at the end and one marking the final byte of a read. The engine drives clock and data as open-drain lines: an enable pulls a line low, and releasing it lets the bus pull-up raise it. Both lines are read back through synchronizers.

All bus timing is counted in system-clock cycles scaled by a cycles-per-microsecond parameter. Every time the engine releases the clock it waits for the line to be seen high, so a target can stretch the clock. That wait is bounded. When the bound runs out, the engine ends the transfer with a stop condition of its own and reports an I/O error. When a command ends, the engine returns a one-cycle done pulse together with the received byte and the acknowledge and error status.

Top module: `i2c_byte_master`

## Requirements
- R1: Command code 0 (start) releases both lines, then pulls SDA low while SCL is high, which forms a start condition. It waits for SCL to be seen high, then pulls SCL low. When done rises, both enables are 1.
- R2: Command code 1 (stop) pulls SDA low, releases SCL, and after about 4 us releases SDA while SCL is high. When done rises, both enables are 0.
- R3: Command code 2 (write) puts the data byte on SDA most significant bit first, one bit for each SCL high phase.
- R4: On a write, SDA is released for a ninth clock and sampled while SCL is high. A high level sets nack to 1 at done, and a low level sets it to 0.
- R5: A write ends with a stop condition whenever the stop flag is set, even after a NACK. Without the stop flag no stop is made, and SCL stays driven low after done.
- R6: Command code 3 (read) releases SDA for eight clocks and shifts the sampled bits into rd_data most significant bit first. rd_data is valid at done and keeps its value while the engine is idle.
- R7: On a read, the ninth clock carries SDA driven low (ACK) when the last flag is 0, and SDA released (NACK) when the last flag is 1.
- R8: A read ends with a stop condition only when both the stop flag and the last flag are set.
- R9: A target that holds SCL low for less than POLL_LIMIT microseconds delays the transfer but does not change its result.
- R10: If SCL is not seen high within POLL_LIMIT microseconds after a release, the engine performs a stop sequence and ends the command with io_err set to 1. At that done both enables are 0.
- R11: cmd_ready is high only while the engine is idle. It falls in the cycle after a command is accepted. done is a single-cycle pulse, and cmd_ready is high while done is high.
- R12: After reset both enables are 0, cmd_ready is 1 and done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle; a command is accepted when both are high |
| cmd_op | input | 2 | 0 start, 1 stop, 2 write, 3 read |
| cmd_data | input | 8 | Byte to send for a write |
| cmd_stop | input | 1 | Request a stop condition at the end |
| cmd_last | input | 1 | Final byte of a read (answer with NACK) |
| scl_i | input | 1 | SCL level as seen on the bus |
| sda_i | input | 1 | SDA level as seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| done | output | 1 | One-cycle pulse at the end of a command |
| rd_data | output | 8 | Byte received by the last read |
| nack | output | 1 | Target did not acknowledge the written byte |
| io_err | output | 1 | SCL wait timed out; a stop condition was made |

## Verification
The hardest case to reach from the ports is the SCL timeout. The engine itself releases SCL, so the line can stay low only if a target keeps pulling it down. The bench's target model can be told to hold SCL low after a chosen falling edge for a set number of cycles. A hold shorter than the poll window checks that the transfer still completes, and a longer hold forces the timeout path and the stop sequence that follows it. The flag combinations that decide the read acknowledge and the closing stop are each given their own read command, and start and stop conditions are counted directly on the bus.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_STOP  = 2'd1,
      OP_WRITE = 2'd2,
      OP_READ  = 2'd3
   } op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_BUF,
      ST_SWAIT,
      ST_SHOLD,
      ST_SLOW,
      ST_SETUP,
      ST_BWAIT,
      ST_BHIGH,
      ST_BLOW,
      ST_TAIL,
      ST_PSTOP,
      ST_STSU,
      ST_STEND
   } st_e;

   function automatic logic is_wait(st_e s);
      return (s == ST_SWAIT) || (s == ST_BWAIT);
   endfunction

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("i2cm_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cm_timer.sv
module i2cm_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/i2cm_poll_guard.sv
module i2cm_poll_guard #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic hit
);
   localparam int CW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 1) begin : g_bad
         $error("i2cm_poll_guard: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (step)  cnt <= cnt + 1'b1;
   end

   assign hit = step && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
   import i2cm_pkg::*;
#(
   parameter int CLK_PER_US  = 100,
   parameter int POLL_LIMIT  = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   output logic       cmd_ready,
   input  logic [1:0] cmd_op,
   input  logic [7:0] cmd_data,
   input  logic       cmd_stop,
   input  logic       cmd_last,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       scl_oe,
   output logic       sda_oe,
   output logic       done,
   output logic [7:0] rd_data,
   output logic       nack,
   output logic       io_err
);
   localparam int T1 = CLK_PER_US;
   localparam int T4 = 4 * CLK_PER_US;
   localparam int T5 = 5 * CLK_PER_US;
   localparam int TW = $clog2(T5 + 1);

   generate
      if (CLK_PER_US < 1) begin : g_bad_clk
         $error("i2c_byte_master: CLK_PER_US must be at least 1");
      end
   endgenerate

   logic scl_s, sda_s;
   i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (.clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (.clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   st_e        st_q, st_n;
   op_e        op_q, op_n;
   logic [3:0] bit_q, bit_n;
   logic [7:0] sh_q, sh_n, rx_q, rx_n;
   logic       stop_q, stop_n, last_q, last_n;
   logic       nack_q, nack_n, err_q, err_n, done_q, done_n;
   logic       scl_oe_q, sda_oe_q, drv;

   logic          t_zero, t_load, to_hit;
   logic [TW-1:0] t_val;
   int            dur_n;

   i2cm_timer #(.W(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .val(t_val), .zero(t_zero)
   );

   i2cm_poll_guard #(.LIMIT(POLL_LIMIT)) u_guard (
      .clk(clk), .rst_n(rst_n), .clr(st_n != st_q),
      .step(is_wait(st_q) && t_zero), .hit(to_hit)
   );

   // next-state sequencing
   always_comb begin
      st_n = st_q;  op_n = op_q;  bit_n = bit_q;  sh_n = sh_q;  rx_n = rx_q;
      stop_n = stop_q;  last_n = last_q;  nack_n = nack_q;  err_n = err_q;
      done_n = 1'b0;
      case (st_q)
         ST_IDLE: if (cmd_valid) begin
            op_n = op_e'(cmd_op);  sh_n = cmd_data;  bit_n = '0;
            stop_n = cmd_stop;  last_n = cmd_last;  nack_n = 1'b0;  err_n = 1'b0;
            case (op_e'(cmd_op))
               OP_START: st_n = ST_BUF;
               OP_STOP:  st_n = ST_PSTOP;
               default:  st_n = ST_SETUP;
            endcase
         end
         ST_BUF:   if (t_zero) st_n = ST_SWAIT;
         ST_SWAIT: if (scl_s) st_n = ST_SHOLD;
                   else if (to_hit) begin err_n = 1'b1; st_n = ST_PSTOP; end
         ST_SHOLD: if (t_zero) st_n = ST_SLOW;
         ST_SLOW:  if (t_zero) begin st_n = ST_IDLE; done_n = 1'b1; end
         ST_SETUP: if (t_zero) st_n = ST_BWAIT;
         ST_BWAIT: if (scl_s) st_n = ST_BHIGH;
                   else if (to_hit) begin err_n = 1'b1; st_n = ST_PSTOP; end
         ST_BHIGH: if (t_zero) begin
            if (op_q == OP_READ && bit_q < 4'd8)  rx_n = {rx_q[6:0], sda_s};
            if (op_q == OP_WRITE && bit_q == 4'd8) nack_n = sda_s;
            st_n = ST_BLOW;
         end
         ST_BLOW: if (t_zero) begin
            if (bit_q == 4'd8) st_n = ST_TAIL;
            else begin
               bit_n = bit_q + 4'd1;
               if (op_q == OP_WRITE) sh_n = {sh_q[6:0], 1'b0};
               st_n = ST_SETUP;
            end
         end
         ST_TAIL: if (t_zero) begin
            if (stop_q && (op_q == OP_WRITE || last_q)) st_n = ST_PSTOP;
            else begin st_n = ST_IDLE; done_n = 1'b1; end
         end
         ST_PSTOP: if (t_zero) st_n = ST_STSU;
         ST_STSU:  if (t_zero) st_n = ST_STEND;
         ST_STEND: begin st_n = ST_IDLE; done_n = 1'b1; end
         default:  st_n = ST_IDLE;
      endcase
   end

   // phase length of the state being entered
   always_comb begin
      case (st_n)
         ST_BUF, ST_SLOW, ST_BLOW, ST_TAIL: dur_n = T5;
         ST_SHOLD, ST_BHIGH, ST_STSU:       dur_n = T4;
         ST_SETUP: dur_n = (op_n == OP_WRITE && bit_n == 4'd8) ? T5 : T1;
         ST_PSTOP, ST_SWAIT, ST_BWAIT:      dur_n = T1;
         default:                           dur_n = 1;
      endcase
   end

   assign t_val  = TW'(dur_n - 1);
   assign t_load = (st_n != st_q) || (is_wait(st_q) && t_zero);

   // data-line level for the current bit slot
   assign drv = (op_q == OP_WRITE) ? ((bit_q < 4'd8) && !sh_q[7])
                                   : ((bit_q == 4'd8) && !last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;  op_q <= OP_START;  bit_q <= '0;  sh_q <= '0;  rx_q <= '0;
         stop_q <= 1'b0;  last_q <= 1'b0;  nack_q <= 1'b0;  err_q <= 1'b0;  done_q <= 1'b0;
      end else begin
         st_q <= st_n;  op_q <= op_n;  bit_q <= bit_n;  sh_q <= sh_n;  rx_q <= rx_n;
         stop_q <= stop_n;  last_q <= last_n;  nack_q <= nack_n;  err_q <= err_n;  done_q <= done_n;
      end
   end

   // registered line drivers; idle keeps the bus as the last command left it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_oe_q <= 1'b0;  sda_oe_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE:            begin scl_oe_q <= scl_oe_q; sda_oe_q <= sda_oe_q; end
            ST_BUF, ST_STEND:   begin scl_oe_q <= 1'b0;     sda_oe_q <= 1'b0;     end
            ST_SWAIT, ST_SHOLD,
            ST_STSU:            begin scl_oe_q <= 1'b0;     sda_oe_q <= 1'b1;     end
            ST_SLOW:            begin scl_oe_q <= 1'b1;     sda_oe_q <= 1'b1;     end
            ST_SETUP, ST_BLOW:  begin scl_oe_q <= 1'b1;     sda_oe_q <= drv;      end
            ST_BWAIT, ST_BHIGH: begin scl_oe_q <= 1'b0;     sda_oe_q <= drv;      end
            ST_TAIL:            begin scl_oe_q <= 1'b1;     sda_oe_q <= 1'b0;     end
            ST_PSTOP:           begin scl_oe_q <= scl_oe_q; sda_oe_q <= 1'b1;     end
            default:            begin scl_oe_q <= 1'b0;     sda_oe_q <= 1'b0;     end
         endcase
      end
   end

   assign cmd_ready = (st_q == ST_IDLE);
   assign scl_oe    = scl_oe_q;
   assign sda_oe    = sda_oe_q;
   assign done      = done_q;
   assign rd_data   = rx_q;
   assign nack      = nack_q;
   assign io_err    = err_q;
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic       cmd_ready,
   input logic       done,
   input logic       io_err,
   input logic       nack,
   input logic       scl_oe,
   input logic       sda_oe,
   input logic [7:0] rd_data
);
   AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready |=> !cmd_ready); // R11

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11

   AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cmd_ready); // R11

   AST_TIMEOUT_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      done && io_err |-> !scl_oe && !sda_oe); // R10

   AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(io_err && nack)); // R4

   AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready && !cmd_valid && !done |=> $stable(rd_data)); // R6
endmodule

bind i2c_byte_master i2cm_checker u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .done(done), .io_err(io_err), .nack(nack), .scl_oe(scl_oe), .sda_oe(sda_oe),
   .rd_data(rd_data)
);

// File: tb/i2c_byte_master_test.sv
`timescale 1ns/100ps
module i2c_byte_master_test;
   localparam int CPU = 4;
   localparam int PL  = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'd0;
   logic [7:0] cmd_data = 8'h00;
   logic       cmd_stop = 1'b0, cmd_last = 1'b0;
   logic       cmd_ready, scl_oe, sda_oe, done, nack, io_err;
   logic [7:0] rd_data;

   logic tgt_scl_low = 1'b0, tgt_sda_low = 1'b0;
   wire  scl_bus = !scl_oe && !tgt_scl_low;
   wire  sda_bus = !sda_oe && !tgt_sda_low;

   i2c_byte_master #(.CLK_PER_US(CPU), .POLL_LIMIT(PL)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_stop(cmd_stop), .cmd_last(cmd_last),
      .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .done(done), .rd_data(rd_data), .nack(nack), .io_err(io_err)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   // ---------------- target model ----------------
   int         tgt_mode = 0;   // 0 passive, 1 receive, 2 transmit
   logic       tgt_ack = 1'b1;
   logic [7:0] tgt_tx = 8'h00, tgt_rx = 8'h00;
   int         bitcnt = 0;
   logic       ack_seen = 1'b0;
   int         stretch_n = 0;
   int         n_start = 0, n_stop = 0;

   function automatic logic tdrive();
      if (tgt_mode == 1) return (bitcnt == 8) && tgt_ack;
      if (tgt_mode == 2) return (bitcnt < 8) && !tgt_tx[7 - bitcnt];
      return 1'b0;
   endfunction

   always @(posedge scl_bus) begin
      if (bitcnt < 8)       tgt_rx = {tgt_rx[6:0], sda_bus};
      else if (bitcnt == 8) ack_seen = sda_bus;
      bitcnt++;
   end

   always @(negedge scl_bus) begin
      tgt_sda_low = tdrive();
      if (stretch_n > 0) begin
         int k;
         k = stretch_n;
         stretch_n = 0;
         tgt_scl_low = 1'b1;
         repeat (k) @(posedge clk);
         tgt_scl_low = 1'b0;
      end
   end

   always @(negedge sda_bus) if (scl_bus === 1'b1) n_start++;
   always @(posedge sda_bus) if (scl_bus === 1'b1) n_stop++;

   // ---------------- scoreboard ----------------
   typedef struct packed {
      logic [7:0] rd;
      logic       chk_rd;
      logic       nk;
      logic       er;
   } exp_t;
   exp_t  exq[$];
   string tagq[$];

   always @(negedge clk) begin
      if (rst_n && done === 1'b1) begin
         if (exq.size() == 0) begin
            chk("R11 unexpected done", 32'd1, 32'd0);
         end else begin
            exp_t  e;
            string t;
            e = exq.pop_front();
            t = tagq.pop_front();
            chk({t, " nack"}, {31'd0, nack}, {31'd0, e.nk});
            chk({t, " io_err"}, {31'd0, io_err}, {31'd0, e.er});
            if (e.chk_rd) chk({t, " rd_data"}, {24'd0, rd_data}, {24'd0, e.rd});
         end
      end
   end

   task automatic issue(input logic [1:0] op, input logic [7:0] data, input logic stp,
                        input logic lst, input logic [7:0] erd, input logic crd,
                        input logic enk, input logic eer, input string tag);
      exp_t e;
      e.rd = erd; e.chk_rd = crd; e.nk = enk; e.er = eer;
      exq.push_back(e);
      tagq.push_back(tag);
      while (!cmd_ready) @(negedge clk);
      tgt_mode = (op == 2'd2) ? 1 : (op == 2'd3) ? 2 : 0;
      bitcnt = 0;
      ack_seen = 1'bx;
      tgt_sda_low = tdrive();
      cmd_valid = 1'b1; cmd_op = op; cmd_data = data; cmd_stop = stp; cmd_last = lst;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R11 ready low after accept", {31'd0, cmd_ready}, 32'd0);
      while (done !== 1'b1) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk("watchdog expired", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_start = 0; n_stop = 0;
      // R12 reset state
      chk("R12 scl_oe", {31'd0, scl_oe}, 32'd0);
      chk("R12 sda_oe", {31'd0, sda_oe}, 32'd0);
      chk("R12 cmd_ready", {31'd0, cmd_ready}, 32'd1);
      chk("R12 done", {31'd0, done}, 32'd0);

      // R1 start
      issue(2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R1 start");
      chk("R1 start condition", n_start, 1);
      chk("R1 lines low", {30'd0, scl_oe, sda_oe}, 32'd3);

      // R3 write, no stop
      tgt_ack = 1'b1;
      issue(2'd2, 8'hA5, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R4 write ack");
      chk("R3 byte msb first", {24'd0, tgt_rx}, 32'hA5);
      chk("R5 no stop without flag", n_stop, 0);
      chk("R5 scl held low", {31'd0, scl_oe}, 32'd1);

      // R4/R5 NACK with stop flag
      tgt_ack = 1'b0;
      issue(2'd2, 8'h3C, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R4 write nack");
      chk("R3 second byte", {24'd0, tgt_rx}, 32'h3C);
      chk("R5 stop after nack", n_stop, 1);
      chk("R5 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);

      // R6/R7/R8 reads
      issue(2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R1 restart");
      chk("R1 second start", n_start, 2);
      tgt_tx = 8'h96;
      issue(2'd3, 8'h00, 1'b1, 1'b0, 8'h96, 1'b1, 1'b0, 1'b0, "R6 read 96");
      chk("R7 ack low when not last", {31'd0, ack_seen}, 32'd0);
      chk("R8 no stop without last", n_stop, 1);
      tgt_tx = 8'h41;
      issue(2'd3, 8'h00, 1'b0, 1'b1, 8'h41, 1'b1, 1'b0, 1'b0, "R6 read 41");
      chk("R7 nack when last", {31'd0, ack_seen}, 32'd1);
      chk("R8 no stop without stop flag", n_stop, 1);
      tgt_tx = 8'hC3;
      issue(2'd3, 8'h00, 1'b1, 1'b1, 8'hC3, 1'b1, 1'b0, 1'b0, "R6 read C3");
      chk("R8 stop with stop and last", n_stop, 2);
      chk("R8 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);

      // R9 short stretch, then R2 stop command
      issue(2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R1 start 3");
      tgt_ack = 1'b1;
      stretch_n = 60;
      issue(2'd2, 8'h5A, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R9 stretched write");
      chk("R9 byte intact", {24'd0, tgt_rx}, 32'h5A);
      issue(2'd1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R2 stop");
      chk("R2 stop condition", n_stop, 3);
      chk("R2 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);

      // R10 timeout
      issue(2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R1 start 4");
      stretch_n = 300;
      issue(2'd2, 8'h77, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R10 timeout");
      chk("R10 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);
      while (tgt_scl_low) @(negedge clk);
      repeat (20) @(negedge clk);
      chk("R11 no pending results", exq.size(), 0);
      finish_run();
   end
endmodule